// File: doc/BRIEF.md
# SAR Converter Serial Port Emulator

This block is a synthesizable, clock-synchronous model of the digital side of a 12-bit successive-approximation converter. It stands in for the converter when a host controller is under test. A rising edge on the conversion-start pin begins a timed conversion. At that moment the block takes a sample from one of four parallel code inputs, and the multiplexer setting currently in force picks which one. When the timer expires, the formatted result goes into an output shift register. The block then drives the result serially, MSB first, on a three-state data pin. It advances one bit on each falling edge of the serial clock. While the result shifts out, it takes a 6-bit configuration word from the serial input on the rising edges. That word sets the channel, the polarity and the output format for the next conversion.

All pins are sampled on the system clock `clk`. The serial clock and the conversion-start pin must each hold every level for at least two `clk` cycles. The sample bus has no handshake. The block never stalls, and it reads the bus only in the cycle in which a conversion starts. The host therefore only has to hold the codes steady around the conversion-start edge. The status outputs report whether a conversion is running, whether the device sleeps, whether it is acquiring, and the configuration in force.

Top module: `sar_port_emu`

## Requirements
- R1: A rising edge on `convst` while idle starts a conversion, and `busy` is high for exactly CONV_CYCLES cycles. A rising edge seen while `busy` is high neither restarts nor extends the conversion.
- R2: `sdo_oe` is 0 whenever `convst` is high and 1 whenever it is low. `sdo` is high-impedance when `sdo_oe` is 0.
- R3: In the cycle after `busy` falls, the output register holds the result. If `convst` is already low, the result MSB is on `sdo` without any `sck` pulse.
- R4: Each falling edge of `sck` seen while `convst` is low and `busy` is low advances `sdo` by one bit, from MSB to LSB. After 12 falls `sdo` reads 0. Edges of `sck` during a conversion have no effect.
- R5: The first six rising edges of `sck` after `convst` falls (outside a conversion) capture `sdi`. Bit 1 of the frame is S/D, bit 2 is O/S and bit 5 is UNI. Bits 3, 4 and 6 and all later rising edges are ignored.
- R6: `mux_sel` = {S/D, O/S}. The codes are: 0 = CH0 positive and CH1 negative, 1 = CH1 positive and CH0 negative, 2 = CH0 against ground, 3 = CH1 against ground. A conversion samples `smp_code[mux_sel]`. With TWO_CH = 0, S/D is ignored and `mux_sel[1]` stays 0.
- R7: A new configuration takes effect only on the 6th captured bit. At that point `acquiring` rises, and it stays high until the next conversion starts.
- R8: If `convst` is high when a conversion ends, `asleep` rises. It falls one cycle after `convst` is seen low.
- R9: With UNI = 1 the result equals the selected code (straight binary). With UNI = 0 the result is the selected code with its MSB inverted (two's complement of an offset-binary input).
- R10: After reset, `busy`, `asleep` and `acquiring` are 0. `mux_sel` is 0 and `uni_mode` is 0. The output register is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| convst | input | 1 | Conversion start; high also releases `sdo` |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial configuration input |
| smp_code | input | 4 x DATA_W | Offset-binary codes, indexed by multiplexer code |
| sdo | output | 1 | Three-state serial result output |
| sdo_oe | output | 1 | High when `sdo` is driven |
| busy | output | 1 | Conversion in progress |
| asleep | output | 1 | Sleep state |
| acquiring | output | 1 | Configuration taken, acquiring for next conversion |
| mux_sel | output | 2 | Multiplexer code in force |
| uni_mode | output | 1 | 1 = straight binary, 0 = two's complement |

## Verification
The bench builds two copies of the block on shared pins. One has CONV_CYCLES = 24 and TWO_CH = 1, and the other has the same timing with TWO_CH = 0. The short conversion leaves room to force a second rising edge of `convst` and a full `sck` pulse into the middle of one conversion, while still fitting both the sleep exit and the early-low exit into a brief run. The single-channel copy receives the same configuration frames, so the bench can show that S/D is dropped while O/S still acts.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;
  // Number of selectable sample sources (multiplexer codes)
  localparam int MUX_SRCS = 4;
  // Length of the serial configuration frame
  localparam int CFG_BITS = 6;
  // Position (0 = first bit sent) of the fields within the frame
  localparam int POS_SD  = 0;
  localparam int POS_OS  = 1;
  localparam int POS_UNI = 4;

  typedef struct packed {
    logic sd;   // 1 = single-ended against ground
    logic os;   // selects the odd channel / swaps polarity
    logic uni;  // 1 = straight binary, 0 = two's complement
  } cfg_t;
endpackage

// File: rtl/sar_edge.sv
module sar_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= din;
  end

  assign rise = din & ~prev_q;
  assign fall = ~din & prev_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int CONV_CYCLES = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic convst,
  input  logic convst_rise,
  output logic busy,
  output logic start,
  output logic finish,
  output logic asleep
);
  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign start  = convst_rise & ~busy;
  assign finish = busy & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= LAST;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       asleep <= 1'b0;
    else if (finish)  asleep <= convst;
    else if (!convst) asleep <= 1'b0;
  end

  AST_CONV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt_q != '0 |=> busy);  // R1
  AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && !convst |=> !asleep);  // R8
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(busy));  // R8
endmodule

// File: rtl/sar_port_shift.sv
module sar_port_shift import sar_port_pkg::*; #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convst,
  input  logic              convst_fall,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi,
  input  logic              busy,
  input  logic              start,
  input  logic              finish,
  input  logic [DATA_W-1:0] load_word,
  output logic              sdo_bit,
  output cfg_t              cfg_q,
  output logic              acquiring
);
  localparam int NW = $clog2(CFG_BITS + 1);
  localparam logic [NW-1:0] LAST_BIT = NW'(CFG_BITS - 1);
  localparam logic [NW-1:0] ALL_BITS = NW'(CFG_BITS);

  logic [DATA_W-1:0] shreg_q;
  logic [NW-1:0]     bit_cnt_q;
  cfg_t              pend_q;
  logic              take_bit;
  logic              commit;

  assign take_bit = sck_rise & ~convst & ~busy & (bit_cnt_q < ALL_BITS);
  assign commit   = take_bit & (bit_cnt_q == LAST_BIT);
  assign sdo_bit  = shreg_q[DATA_W-1];

  // Output latches: loaded at end of conversion, shifted on sck falls
  always_ff @(posedge clk) begin
    if (!rst_n)                           shreg_q <= '0;
    else if (finish)                      shreg_q <= load_word;
    else if (sck_fall && !convst && !busy) shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
  end

  // Configuration frame capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      pend_q    <= '0;
      cfg_q     <= '0;
    end else if (convst_fall) begin
      bit_cnt_q <= '0;
    end else if (take_bit) begin
      bit_cnt_q <= bit_cnt_q + 1'b1;
      if (bit_cnt_q == NW'(POS_SD))  pend_q.sd  <= sdi;
      if (bit_cnt_q == NW'(POS_OS))  pend_q.os  <= sdi;
      if (bit_cnt_q == NW'(POS_UNI)) pend_q.uni <= sdi;
      if (commit)                    cfg_q      <= pend_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      acquiring <= 1'b0;
    else if (start)  acquiring <= 1'b0;
    else if (commit) acquiring <= 1'b1;
  end

  AST_CFG_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q <= ALL_BITS);  // R5
  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> sdo_bit == $past(load_word[DATA_W-1]));  // R3
  AST_HOLD_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !finish |=> $stable(shreg_q));  // R4
  AST_CFG_ONLY_AT_SIXTH: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q != LAST_BIT |=> $stable(cfg_q));  // R7
endmodule

// File: rtl/sar_port_emu.sv
module sar_port_emu import sar_port_pkg::*; #(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 48,
  parameter bit TWO_CH      = 1'b1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             convst,
  input  logic                             sck,
  input  logic                             sdi,
  input  logic [MUX_SRCS-1:0][DATA_W-1:0]  smp_code,
  output logic                             sdo,
  output logic                             sdo_oe,
  output logic                             busy,
  output logic                             asleep,
  output logic                             acquiring,
  output logic [1:0]                       mux_sel,
  output logic                             uni_mode
);
  logic cv_rise, cv_fall, ck_rise, ck_fall;
  logic conv_start, conv_finish, sdo_bit;
  cfg_t cfg_q;
  logic [DATA_W-1:0] fmt_w, held_q;

  sar_edge u_cv_edge (.clk(clk), .rst_n(rst_n), .din(convst), .rise(cv_rise), .fall(cv_fall));
  sar_edge u_ck_edge (.clk(clk), .rst_n(rst_n), .din(sck),    .rise(ck_rise), .fall(ck_fall));

  sar_conv_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .convst(convst), .convst_rise(cv_rise),
    .busy(busy), .start(conv_start), .finish(conv_finish), .asleep(asleep)
  );

  sar_port_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .convst(convst), .convst_fall(cv_fall),
    .sck_rise(ck_rise), .sck_fall(ck_fall), .sdi(sdi), .busy(busy),
    .start(conv_start), .finish(conv_finish), .load_word(held_q),
    .sdo_bit(sdo_bit), .cfg_q(cfg_q), .acquiring(acquiring)
  );

  // Channel decode: the single-channel variant drops S/D
  generate
    if (TWO_CH) begin : g_two_ch
      assign mux_sel = {cfg_q.sd, cfg_q.os};
    end else begin : g_one_ch
      assign mux_sel = {1'b0, cfg_q.os};
    end
  endgenerate

  assign uni_mode = cfg_q.uni;

  // Output format: bipolar flips the MSB of the offset-binary code
  always_comb begin
    fmt_w = smp_code[mux_sel];
    if (!cfg_q.uni) fmt_w[DATA_W-1] = ~fmt_w[DATA_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          held_q <= '0;
    else if (conv_start) held_q <= fmt_w;
  end

  assign sdo_oe = ~convst;
  assign sdo    = convst ? 1'bz : sdo_bit;

  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(held_q));  // R1
endmodule

// File: tb/sar_port_emu_bench.sv
module sar_port_emu_bench;
  localparam int W = 12;
  localparam int CONV = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic convst = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [3:0][W-1:0] smp;
  wire  sdo, sdo_b;
  logic sdo_oe, busy, asleep, acquiring, uni_mode;
  logic [1:0] mux_sel;
  logic sdo_oe_b, busy_b, asleep_b, acq_b, uni_b;
  logic [1:0] mux_b;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] obs_word;
  event frame_done;
  logic [1:0] exp_mux = 2'd0;
  logic exp_uni = 1'b0;

  always #4 clk = ~clk;

  sar_port_emu #(.DATA_W(W), .CONV_CYCLES(CONV), .TWO_CH(1'b1)) u_sar_port_emu (
    .clk(clk), .rst_n(rst_n), .convst(convst), .sck(sck), .sdi(sdi), .smp_code(smp),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .asleep(asleep), .acquiring(acquiring),
    .mux_sel(mux_sel), .uni_mode(uni_mode));

  sar_port_emu #(.DATA_W(W), .CONV_CYCLES(CONV), .TWO_CH(1'b0)) u_one (
    .clk(clk), .rst_n(rst_n), .convst(convst), .sck(sck), .sdi(sdi), .smp_code(smp),
    .sdo(sdo_b), .sdo_oe(sdo_oe_b), .busy(busy_b), .asleep(asleep_b), .acquiring(acq_b),
    .mux_sel(mux_b), .uni_mode(uni_b));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic logic [W-1:0] fmt(input logic [W-1:0] c, input logic uni);
    fmt = c;
    if (!uni) fmt[W-1] = ~fmt[W-1];
  endfunction

  // Monitor: pops expected results and compares each collected frame
  initial begin
    forever begin
      @(frame_done);
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected frame", obs_word, 0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(obs_word == e, "R4/R6/R9 frame data", obs_word, e);
      end
    end
  end

  task automatic sck_pulse(input logic d);
    @(negedge clk); sdi = d; sck = 1'b1;
    repeat (2) @(negedge clk);
    sck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Driver: start a conversion and push its expected result
  task automatic conv_sleep();
    exp_q.push_back(fmt(smp[exp_mux], exp_uni));
    @(negedge clk); convst = 1'b1;
    repeat (5) @(negedge clk);
    convst = 1'b0;                       // R1 extra rising edge follows
    repeat (2) @(negedge clk);
    convst = 1'b1;
    repeat (CONV - 7) @(negedge clk);
    check(busy == 1'b1, "R1 busy through full window", busy, 1);
    @(negedge clk);
    check(busy == 1'b0, "R1 conversion length not extended", busy, 0);
    check(asleep == 1'b1, "R8 sleep after end with convst high", asleep, 1);
    check(sdo_oe == 1'b0, "R2 sdo released while convst high", sdo_oe, 0);
    convst = 1'b0;
    #1 check(sdo_oe == 1'b1, "R2 sdo driven while convst low", sdo_oe, 1);
    @(negedge clk);
    check(asleep == 1'b0, "R8 wake on convst low", asleep, 0);
  endtask

  task automatic conv_early();
    logic [W-1:0] e;
    e = fmt(smp[exp_mux], exp_uni);
    exp_q.push_back(e);
    @(negedge clk); convst = 1'b1;
    repeat (3) @(negedge clk);
    convst = 1'b0;
    sck_pulse(1'b1);                     // R4 ignored during conversion
    check(busy == 1'b1, "R1 still converting", busy, 1);
    check(acquiring == 1'b0, "R7 acquiring cleared at start", acquiring, 0);
    while (busy) @(negedge clk);
    check(sdo == e[W-1], "R3 MSB on sdo at end of conversion", sdo, e[W-1]);
  endtask

  task automatic read_frame(input logic [5:0] w);
    logic [1:0] m_before;
    m_before = mux_sel;
    for (int i = 0; i < W; i++) begin
      obs_word[W-1-i] = sdo;
      if (i == 5)
        check(mux_sel == m_before, "R7 config not applied before 6th bit", mux_sel, m_before);
      sck_pulse(i < 6 ? w[i] : ~w[i % 6]);
    end
    ->frame_done;
    check(sdo == 1'b0, "R4 zeros after LSB", sdo, 0);
    exp_mux = {w[0], w[1]};
    exp_uni = w[4];
    check(mux_sel == exp_mux, "R5/R6 mux code decoded", mux_sel, exp_mux);
    check(uni_mode == exp_uni, "R5/R9 uni captured", uni_mode, exp_uni);
    check(acquiring == 1'b1, "R7 acquiring after 6th bit", acquiring, 1);
    check(mux_b == {1'b0, w[1]}, "R6 single-channel ignores S/D", mux_b, {1'b0, w[1]});
  endtask

  initial begin
    smp[0] = 12'h123; smp[1] = 12'h9AB; smp[2] = 12'h800; smp[3] = 12'hFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(busy == 1'b0, "R10 busy", busy, 0);
    check(asleep == 1'b0, "R10 asleep", asleep, 0);
    check(acquiring == 1'b0, "R10 acquiring", acquiring, 0);
    check(mux_sel == 2'd0, "R10 mux_sel", mux_sel, 0);
    check(uni_mode == 1'b0, "R10 uni_mode", uni_mode, 0);
    check(sdo_oe == 1'b1 && sdo == 1'b0, "R10 output register zero", sdo, 0);

    // frame bits: {b5,b4 UNI,b3,b2,b1 O/S,b0 S/D}
    conv_sleep();  read_frame(6'b111110);   // -> mux 1, unipolar
    conv_early();  read_frame(6'b000001);   // -> mux 2, bipolar
    conv_sleep();  read_frame(6'b010011);   // -> mux 3, unipolar
    conv_early();  read_frame(6'b101100);   // -> mux 0, bipolar
    smp[0] = 12'h7FE;
    conv_sleep();  read_frame(6'b000000);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R3 every conversion produced a frame", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule